// File: doc/BRIEF.md
# Digital Correlated Double Sampler

This block turns a stream of digitised CCD video samples into one pixel value per pixel period. A timing sequencer marks two windows on the video waveform. One window covers the settled reset level and the other covers the settled signal level. Each window has its own accumulator and its own programmable sample count. Only the first samples of a window, up to its programmed count, are summed. Samples taken outside the windows do not change either sum.

A pixel-start strobe clears both sums and both counters. When the signal window closes, the block forms the difference of the two sums. By default this is signal minus reset, and a polarity bit reverses it for CCDs of the opposite type. The difference is shifted right arithmetically by a programmable amount, which sets the digital gain. It is then clamped to the signed 16-bit range and presented with a one-cycle valid strobe.

The input samples are signed two's complement. The sample clock is 100 MHz, so a window edge can be placed to within 10 ns.

Top module: `cds_pixel_core`

## Requirements
- R1: After reset, `pix_valid` is 0 and `pix_data` is 0.
- R2: A cycle with `pix_start` high clears both sums and both sample counters. A sample presented in that same cycle is not added, even if a window is high.
- R3: Each cycle with `rst_win` high adds the signed `sample_in` to the reset sum, until `cfg_rst_count` samples have been taken. Later samples in the window are ignored.
- R4: Each cycle with `sig_win` high adds the signed `sample_in` to the signal sum, until `cfg_sig_count` samples have been taken. Later samples in the window are ignored.
- R5: A programmed count of 0 leaves the matching sum at 0 for the whole pixel.
- R6: The raw result is signal sum minus reset sum when `cfg_invert` is 0, and reset sum minus signal sum when `cfg_invert` is 1.
- R7: The raw result is shifted right arithmetically (sign-filling, rounding toward minus infinity) by `cfg_shift` bits, with 0 to 31 allowed.
- R8: A shifted value above 32767 is output as 32767 (0x7FFF). A value below -32768 is output as -32768 (0x8000). Values do not wrap.
- R9: `pix_valid` is high for exactly one cycle. That cycle is the one after the first cycle in which `sig_win` is low following a high cycle. `pix_data` carries the result in that cycle.
- R10: Samples presented while both windows are low change neither sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_start | input | 1 | Clears sums and counters for a new pixel |
| rst_win | input | 1 | Reset-level window enable |
| sig_win | input | 1 | Signal-level window enable |
| sample_in | input | 16 | Signed ADC sample |
| cfg_rst_count | input | 10 | Maximum samples taken in the reset window |
| cfg_sig_count | input | 10 | Maximum samples taken in the signal window |
| cfg_shift | input | 5 | Arithmetic right shift applied to the difference |
| cfg_invert | input | 1 | 1 selects reset minus signal |
| pix_data | output | 16 | Signed, clamped pixel value |
| pix_valid | output | 1 | One-cycle strobe for `pix_data` |

## Verification
Constant-level pixels with small shifts test the subtraction order and the polarity bit separately, because swapping the operands changes only the sign. Windows longer than the programmed counts, zero counts, and noisy samples in the gaps between windows show whether the count limit and window gating work: any leaked sample moves the result away from the exact expected value. Full-scale opposite levels with no shift drive both clamps. An odd negative difference shifted by one tells an arithmetic shift apart from a logical shift or a truncating divide. Randomised counts, lengths, shifts and samples then cover the combinations.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int CDS_SAMP_W = 16;
  localparam int CDS_ACC_W  = 26;
  localparam int CDS_CNT_W  = 10;
  localparam int CDS_OUT_W  = 16;
  localparam int CDS_NWIN   = 2;
  localparam int IDX_RST    = 0;
  localparam int IDX_SIG    = 1;
endpackage

// File: rtl/cds_window_acc.sv
module cds_window_acc #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 26,
  parameter int CNT_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     win_en,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic        [CNT_W-1:0]  limit,
  output logic signed [ACC_W-1:0]  sum,
  output logic        [CNT_W-1:0]  count,
  output logic                     take
);
  localparam int EXT_W = ACC_W - SAMP_W;

  // sign extension of one sample to accumulator width
  function automatic logic signed [ACC_W-1:0] widen(input logic signed [SAMP_W-1:0] s);
    return {{EXT_W{s[SAMP_W-1]}}, s};
  endfunction

  assign take = win_en && !clear && (count < limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum   <= '0;
      count <= '0;
    end else if (clear) begin
      sum   <= '0;
      count <= '0;
    end else if (take) begin
      sum   <= sum + widen(sample);
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cds_result_stage.sv
module cds_result_stage #(
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 16,
  parameter int SHIFT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic signed [ACC_W-1:0]  rst_sum,
  input  logic signed [ACC_W-1:0]  sig_sum,
  input  logic        [SHIFT_W-1:0] shift,
  input  logic                     invert,
  output logic        [OUT_W-1:0]  pix_data,
  output logic                     pix_valid
);
  localparam int DIFF_W = ACC_W + 1;
  localparam logic signed [DIFF_W-1:0] OUT_MAX = DIFF_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [DIFF_W-1:0] OUT_MIN = ~OUT_MAX;

  // signed difference one bit wider than the sums, so it never overflows
  function automatic logic signed [DIFF_W-1:0] form_diff(
    input logic signed [ACC_W-1:0] r, input logic signed [ACC_W-1:0] s, input logic inv);
    logic signed [DIFF_W-1:0] rw, sw;
    rw = $signed({r[ACC_W-1], r});
    sw = $signed({s[ACC_W-1], s});
    return inv ? (rw - sw) : (sw - rw);
  endfunction

  // arithmetic shift, then clamp to the output range
  function automatic logic [OUT_W-1:0] scale_sat(
    input logic signed [DIFF_W-1:0] d, input logic [SHIFT_W-1:0] sh);
    logic signed [DIFF_W-1:0] t;
    t = d >>> sh;
    if (t > OUT_MAX)      return OUT_MAX[OUT_W-1:0];
    else if (t < OUT_MIN) return OUT_MIN[OUT_W-1:0];
    else                  return t[OUT_W-1:0];
  endfunction

  logic signed [DIFF_W-1:0] diff;
  assign diff = form_diff(rst_sum, sig_sum, invert);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_data  <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= fire;
      if (fire) pix_data <= scale_sat(diff, shift);
    end
  end
endmodule

// File: rtl/cds_pixel_core.sv
module cds_pixel_core
  import cds_pkg::*;
#(
  parameter int SAMP_W = CDS_SAMP_W,
  parameter int ACC_W  = CDS_ACC_W,
  parameter int CNT_W  = CDS_CNT_W,
  parameter int OUT_W  = CDS_OUT_W,
  localparam int SHIFT_W = $clog2(ACC_W + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pix_start,
  input  logic                     rst_win,
  input  logic                     sig_win,
  input  logic signed [SAMP_W-1:0] sample_in,
  input  logic [CNT_W-1:0]         cfg_rst_count,
  input  logic [CNT_W-1:0]         cfg_sig_count,
  input  logic [SHIFT_W-1:0]       cfg_shift,
  input  logic                     cfg_invert,
  output logic [OUT_W-1:0]         pix_data,
  output logic                     pix_valid
);
  logic [CDS_NWIN-1:0]       win_en;
  logic [CDS_NWIN-1:0]       take_a;
  logic [CNT_W-1:0]          lim_a [CDS_NWIN];
  logic [CNT_W-1:0]          cnt_a [CDS_NWIN];
  logic signed [ACC_W-1:0]   sum_a [CDS_NWIN];

  assign win_en[IDX_RST] = rst_win;
  assign win_en[IDX_SIG] = sig_win;
  assign lim_a[IDX_RST]  = cfg_rst_count;
  assign lim_a[IDX_SIG]  = cfg_sig_count;

  for (genvar w = 0; w < CDS_NWIN; w++) begin : g_win
    cds_window_acc #(.SAMP_W(SAMP_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) acc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (pix_start),
      .win_en(win_en[w]),
      .sample(sample_in),
      .limit (lim_a[w]),
      .sum   (sum_a[w]),
      .count (cnt_a[w]),
      .take  (take_a[w])
    );
  end

  // named internal events for the checker
  logic                    rst_take, sig_take;
  logic signed [ACC_W-1:0] rst_sum, sig_sum;
  logic [CNT_W-1:0]        rst_cnt, sig_cnt;
  assign rst_take = take_a[IDX_RST];
  assign sig_take = take_a[IDX_SIG];
  assign rst_sum  = sum_a[IDX_RST];
  assign sig_sum  = sum_a[IDX_SIG];
  assign rst_cnt  = cnt_a[IDX_RST];
  assign sig_cnt  = cnt_a[IDX_SIG];

  logic sig_win_q;
  logic win_close;
  always_ff @(posedge clk) begin
    if (!rst_n) sig_win_q <= 1'b0;
    else        sig_win_q <= sig_win;
  end
  assign win_close = sig_win_q && !sig_win;

  cds_result_stage #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) res_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (win_close),
    .rst_sum  (rst_sum),
    .sig_sum  (sig_sum),
    .shift    (cfg_shift),
    .invert   (cfg_invert),
    .pix_data (pix_data),
    .pix_valid(pix_valid)
  );
endmodule

// File: rtl/cds_pixel_checker.sv
module cds_pixel_checker #(
  parameter int ACC_W = 26,
  parameter int CNT_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_start,
  input logic                    sig_win,
  input logic                    pix_valid,
  input logic                    rst_take,
  input logic                    sig_take,
  input logic signed [ACC_W-1:0] rst_sum,
  input logic signed [ACC_W-1:0] sig_sum,
  input logic [CNT_W-1:0]        rst_cnt,
  input logic [CNT_W-1:0]        sig_cnt
);
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  assert_valid_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !$past(sig_win));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start |=> (rst_sum == '0 && sig_sum == '0 && rst_cnt == '0 && sig_cnt == '0));

  assert_rst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_start && !rst_take) |=> ($stable(rst_sum) && $stable(rst_cnt)));

  assert_sig_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_start && !sig_take) |=> ($stable(sig_sum) && $stable(sig_cnt)));

  assert_rst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> (rst_cnt == $past(rst_cnt) + 1'b1));

  assert_sig_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sig_take |=> (sig_cnt == $past(sig_cnt) + 1'b1));
endmodule

bind cds_pixel_core cds_pixel_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_start(pix_start),
  .sig_win  (sig_win),
  .pix_valid(pix_valid),
  .rst_take (rst_take),
  .sig_take (sig_take),
  .rst_sum  (rst_sum),
  .sig_sum  (sig_sum),
  .rst_cnt  (rst_cnt),
  .sig_cnt  (sig_cnt)
);

// File: tb/cds_pixel_core_tb.sv
module cds_pixel_core_tb_top;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               pix_start, rst_win, sig_win, cfg_invert;
  logic signed [15:0] sample_in;
  logic [9:0]         cfg_rst_count, cfg_sig_count;
  logic [4:0]         cfg_shift;
  logic [15:0]        pix_data;
  logic               pix_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cds_pixel_core dut_i (
    .clk(clk), .rst_n(rst_n), .pix_start(pix_start), .rst_win(rst_win),
    .sig_win(sig_win), .sample_in(sample_in), .cfg_rst_count(cfg_rst_count),
    .cfg_sig_count(cfg_sig_count), .cfg_shift(cfg_shift), .cfg_invert(cfg_invert),
    .pix_data(pix_data), .pix_valid(pix_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model: order, arithmetic shift, clamp
  function automatic longint model(input longint rs, input longint ss, input int sh, input bit inv);
    longint d;
    d = inv ? (rs - ss) : (ss - rs);
    d = d >>> sh;
    if (d > 32767)  d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      rst_win = 1'b0; sig_win = 1'b0; sample_in = 16'($urandom);
      @(negedge clk);
    end
  endtask

  // one pixel; rnd=1 draws samples at random, otherwise constant levels
  task automatic run_pixel(input int nr, input int ns, input int rc, input int sc,
                           input int sh, input bit inv, input bit rnd,
                           input int rlev, input int slev, input bit overlap, input string req);
    longint rs = 0, ss = 0, exp;
    logic signed [15:0] v;
    cfg_rst_count = 10'(rc); cfg_sig_count = 10'(sc);
    cfg_shift = 5'(sh); cfg_invert = inv;
    pix_start = 1'b1; rst_win = overlap; sig_win = 1'b0; sample_in = 16'sh3039;
    @(negedge clk);
    pix_start = 1'b0;
    gap(3);
    for (int i = 0; i < nr; i++) begin
      v = rnd ? 16'($urandom) : 16'(rlev);
      sample_in = v; rst_win = 1'b1;
      if (i < rc) rs += longint'(v);
      @(negedge clk);
    end
    gap(2);
    for (int i = 0; i < ns; i++) begin
      v = rnd ? 16'($urandom) : 16'(slev);
      sample_in = v; sig_win = 1'b1;
      if (i < sc) ss += longint'(v);
      @(negedge clk);
    end
    sig_win = 1'b0; sample_in = 16'($urandom);
    @(negedge clk);
    exp = model(rs, ss, sh, inv);
    check(pix_valid === 1'b1, {"R9 valid ", req}, longint'(pix_valid), 1);
    check(longint'($signed(pix_data)) == exp, req, longint'($signed(pix_data)), exp);
    sample_in = 16'($urandom);
    @(negedge clk);
    check(pix_valid === 1'b0, "R9 one-cycle valid", longint'(pix_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pix_start = 1'b0; rst_win = 1'b0; sig_win = 1'b0;
    sample_in = '0; cfg_rst_count = '0; cfg_sig_count = '0; cfg_shift = '0; cfg_invert = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_valid === 1'b0, "R1 valid after reset", longint'(pix_valid), 0);
    check(pix_data === 16'h0, "R1 data after reset", longint'(pix_data), 0);

    run_pixel(4, 4, 4, 4, 2, 1'b0, 1'b0, 1000, 3000, 1'b0, "R6 R7 signal minus reset");
    run_pixel(4, 4, 4, 4, 2, 1'b1, 1'b0, 1000, 3000, 1'b0, "R6 inverted polarity");
    run_pixel(9, 3, 5, 3, 0, 1'b0, 1'b0, 700, 100, 1'b0, "R3 reset count limit");
    run_pixel(2, 11, 2, 6, 1, 1'b0, 1'b0, -50, 400, 1'b0, "R4 signal count limit");
    run_pixel(5, 5, 0, 5, 0, 1'b0, 1'b0, 9999, 123, 1'b0, "R5 zero reset count");
    run_pixel(5, 5, 5, 0, 0, 1'b0, 1'b0, 321, 9999, 1'b0, "R5 zero signal count");
    run_pixel(8, 8, 8, 8, 0, 1'b0, 1'b0, -32768, 32767, 1'b0, "R8 clamp high");
    run_pixel(8, 8, 8, 8, 0, 1'b1, 1'b0, -32768, 32767, 1'b0, "R8 clamp low");
    run_pixel(8, 8, 8, 8, 4, 1'b0, 1'b0, -32768, 32767, 1'b0, "R7 R8 shift pulls into range");
    run_pixel(1, 1, 1, 1, 1, 1'b0, 1'b0, 7, 0, 1'b0, "R7 arithmetic shift of -7");
    run_pixel(3, 3, 3, 3, 0, 1'b0, 1'b0, 10, 20, 1'b1, "R2 start wins over sample");
    run_pixel(2, 2, 2, 2, 31, 1'b0, 1'b0, 5, -5, 1'b0, "R7 maximum shift");
    run_pixel(6, 6, 6, 6, 0, 1'b0, 1'b1, 0, 0, 1'b0, "R10 random gaps ignored");

    for (int p = 0; p < 60; p++) begin
      int nr, ns, rc, sc, sh;
      nr = int'($urandom_range(0, 14)); ns = int'($urandom_range(1, 14));
      rc = int'($urandom_range(0, 12)); sc = int'($urandom_range(0, 12));
      sh = int'($urandom_range(0, 20));
      run_pixel(nr, ns, rc, sc, sh, 1'($urandom), 1'b1, 0, 0, 1'($urandom),
                "R3 R4 R6 R7 R8 random pixel");
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule